// File: doc/BRIEF.md
# Interrupt Enable and Mode Controller

This block keeps the interrupt state of an 8-bit processor core. It holds two enable flip-flops and a 2-bit interrupt-mode register:
- The primary flip-flop gates maskable interrupts.
- The shadow flip-flop saves the primary value while a non-maskable interrupt is serviced.
- The mode register selects how an interrupt is vectored.

The decode unit presents each retired instruction's opcode byte with a completion strobe. A flag marks whether the byte is the second byte of the extended-prefix group. The block updates its state on that strobe.

Two instructions return from an interrupt: a return from a non-maskable handler and a return from a maskable handler. Either one opens a request/acknowledge exchange with the stack unit. `pop_req` rises in the cycle after the return completes and stays high until `pop_ack` is seen high on a clock edge. No request can be lost: the stack unit may hold off the acknowledge for any number of cycles. The restore of the primary flag, where one applies, is taken on that acknowledge edge.

The acceptance unit uses `int_enabled`, `nmi_shadow` and `irq_mode`. It reports back with one-cycle accept strobes that clear the flags.

Top module: `intr_ctl`

## Requirements
- R1: After reset, `int_enabled` = 0, `nmi_shadow` = 0, `irq_mode` = 0 and `pop_req` = 0.
- R2: An unprefixed byte 0xFB retired with `insn_done` sets both `int_enabled` and `nmi_shadow` from the following clock edge.
- R3: An unprefixed byte 0xF3 retired with `insn_done` clears both flags from the following clock edge.
- R4: Prefixed bytes set `irq_mode` from the following clock edge:
  - 0x46, 0x4E, 0x66 or 0x6E select mode 0.
  - 0x56 or 0x76 select mode 1.
  - 0x5E or 0x7E select mode 2.
- R5: A prefixed byte 0x45, 0x55, 0x65 or 0x75 (non-maskable return) raises `pop_req` from the next edge.
  - `pop_req` stays high until an edge with `pop_ack` high; it is low after that edge.
  - On that acknowledge edge, `int_enabled` takes the value of `nmi_shadow`.
- R6: A prefixed byte 0x4D, 0x5D, 0x6D or 0x7D (maskable return) runs the same `pop_req` handshake but leaves both flags unchanged.
- R7: `nmi_take` clears `int_enabled` at the next edge and leaves `nmi_shadow` unchanged. It overrides any enable or restore in the same cycle.
- R8: `irq_take` clears both flags at the next edge. It overrides any enable or restore in the same cycle.
- R9: Bytes other than those listed, a listed byte with the wrong prefix flag, and any byte without `insn_done` change no flag and not the mode.
- R10: While `pop_req` is high, `insn_done` is ignored. `pop_ack` has no effect while `pop_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction-complete strobe |
| insn_prefixed | input | 1 | Byte is an extended-prefix second byte |
| insn_code | input | 8 | Opcode byte of the completed instruction |
| nmi_take | input | 1 | Non-maskable interrupt accepted |
| irq_take | input | 1 | Maskable interrupt accepted |
| pop_req | output | 1 | Return-address pop requested |
| pop_ack | input | 1 | Stack unit has popped the return address |
| int_enabled | output | 1 | Primary enable flag |
| nmi_shadow | output | 1 | Shadow enable flag |
| irq_mode | output | 2 | Interrupt mode |

## Verification
The assertions assume that the accept strobes and `pop_ack` are single-cycle events sampled at the clock edge. They also assume the stack unit acknowledges only what it was asked for.

The stimulus is random:
- Each accept input is raised with low probability in any cycle.
- `pop_ack` is driven freely, including while no request is pending, which exercises the R10 case.
- `insn_done` also arrives during a pending return.

Opcode bytes are drawn mostly from the listed encodings, with an unprefixed or random byte added often, so that aliases and near-misses both occur.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int MODE_W = 2;

  typedef enum logic {
    RET_MASKABLE = 1'b0,
    RET_NONMASK  = 1'b1
  } ret_kind_e;

  typedef struct packed {
    logic              set_en;
    logic              clr_en;
    logic              mode_wr;
    logic [MODE_W-1:0] mode_val;
    logic              ret_go;
    ret_kind_e         ret_kind;
  } insn_dec_t;
endpackage

// File: rtl/intr_op_decode.sv
module intr_op_decode
  import intr_pkg::*;
#(
  parameter int OP_W = 8,
  parameter logic [OP_W-1:0] EN_CODE = 8'hFB,
  parameter logic [OP_W-1:0] DIS_CODE = 8'hF3
) (
  input  logic            valid,
  input  logic            prefixed,
  input  logic [OP_W-1:0] code,
  output insn_dec_t       dec
);
  // Extended group: top two bits 01, low three bits pick the class.
  logic grp01;
  logic is_mode_op;
  logic is_ret_op;

  assign grp01      = (code[7:6] == 2'b01);
  assign is_mode_op = grp01 && (code[2:0] == 3'b110);
  assign is_ret_op  = grp01 && (code[2:0] == 3'b101);

  always_comb begin
    dec = '0;
    if (valid) begin
      if (!prefixed) begin
        dec.set_en = (code == EN_CODE);
        dec.clr_en = (code == DIS_CODE);
      end else begin
        if (is_mode_op) begin
          dec.mode_wr = 1'b1;
          // Bit 5 is a don't-care alias bit; bits 4:3 select the mode.
          unique case (code[4:3])
            2'b10:   dec.mode_val = MODE_W'(1);
            2'b11:   dec.mode_val = MODE_W'(2);
            default: dec.mode_val = MODE_W'(0);
          endcase
        end
        if (is_ret_op) begin
          dec.ret_go   = 1'b1;
          dec.ret_kind = code[3] ? RET_MASKABLE : RET_NONMASK;
        end
      end
    end
  end

  assert_dec_exclusive_R9: assert final ($countones({dec.set_en, dec.clr_en, dec.mode_wr, dec.ret_go}) <= 1);
endmodule

// File: rtl/intr_ret_seq.sv
module intr_ret_seq
  import intr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  ret_kind_e kind,
  input  logic      pop_ack,
  output logic      pop_req,
  output logic      restore
);
  typedef enum logic {S_IDLE, S_WAIT} seq_state_e;

  seq_state_e state_q;
  ret_kind_e  kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= RET_MASKABLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_WAIT;
          kind_q  <= kind;
        end
        S_WAIT: if (pop_ack) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pop_req = (state_q == S_WAIT);
  assign restore = pop_req && pop_ack && (kind_q == RET_NONMASK);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !pop_ack |=> pop_req);
  assert_req_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && pop_ack |=> !pop_req);
  assert_req_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pop_req) |-> $past(start));
endmodule

// File: rtl/intr_flag_regs.sv
module intr_flag_regs
  import intr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic              restore,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_val,
  input  logic              nmi_take,
  input  logic              irq_take,
  output logic              iff1,
  output logic              iff2,
  output logic [MODE_W-1:0] mode
);
  logic iff1_d;
  logic iff2_d;

  // Instruction effect first, then acceptance clears on top.
  always_comb begin
    iff1_d = iff1;
    iff2_d = iff2;
    if (set_en) begin
      iff1_d = 1'b1;
      iff2_d = 1'b1;
    end else if (clr_en) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (restore) begin
      iff1_d = iff2;
    end
    if (nmi_take) iff1_d = 1'b0;
    if (irq_take) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
      mode <= '0;
    end else begin
      iff1 <= iff1_d;
      iff2 <= iff2_d;
      if (mode_wr) mode <= mode_val;
    end
  end

  assert_nmi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> !iff1);
  assert_nmi_keeps_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take && !irq_take && !set_en && !clr_en |=> $stable(iff2));
  assert_irq_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !iff1 && !iff2);
  assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && !nmi_take && !irq_take |=> iff1 && iff2);
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode));
endmodule

// File: rtl/intr_ctl.sv
module intr_ctl
  import intr_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_done,
  input  logic              insn_prefixed,
  input  logic [OP_W-1:0]   insn_code,
  input  logic              nmi_take,
  input  logic              irq_take,
  output logic              pop_req,
  input  logic              pop_ack,
  output logic              int_enabled,
  output logic              nmi_shadow,
  output logic [MODE_W-1:0] irq_mode
);
  insn_dec_t dec;
  logic      accept;
  logic      restore;

  // Retired instructions are ignored while a return pop is pending.
  assign accept = insn_done && !pop_req;

  intr_op_decode #(.OP_W(OP_W)) u_dec (
    .valid    (accept),
    .prefixed (insn_prefixed),
    .code     (insn_code),
    .dec      (dec)
  );

  intr_ret_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (dec.ret_go),
    .kind    (dec.ret_kind),
    .pop_ack (pop_ack),
    .pop_req (pop_req),
    .restore (restore)
  );

  intr_flag_regs u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (dec.set_en),
    .clr_en   (dec.clr_en),
    .restore  (restore),
    .mode_wr  (dec.mode_wr),
    .mode_val (dec.mode_val),
    .nmi_take (nmi_take),
    .irq_take (irq_take),
    .iff1     (int_enabled),
    .iff2     (nmi_shadow),
    .mode     (irq_mode)
  );

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !pop_ack && !nmi_take && !irq_take |=> $stable(int_enabled) && $stable(nmi_shadow) && $stable(irq_mode));
  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mode != 2'd3);
endmodule

// File: tb/intr_ctl_tb_top.sv
module intr_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       insn_done = 1'b0;
  logic       insn_prefixed = 1'b0;
  logic [7:0] insn_code = 8'h00;
  logic       nmi_take = 1'b0;
  logic       irq_take = 1'b0;
  logic       pop_ack = 1'b0;
  logic       pop_req;
  logic       int_enabled;
  logic       nmi_shadow;
  logic [1:0] irq_mode;

  int checks = 0;
  int errors = 0;

  // Expected state
  logic       e1 = 1'b0, e2 = 1'b0, ebusy = 1'b0, ekind_nmi = 1'b0;
  logic [1:0] emode = 2'd0;

  always #2 clk = ~clk;

  intr_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .insn_prefixed(insn_prefixed),
    .insn_code(insn_code), .nmi_take(nmi_take), .irq_take(irq_take),
    .pop_req(pop_req), .pop_ack(pop_ack), .int_enabled(int_enabled),
    .nmi_shadow(nmi_shadow), .irq_mode(irq_mode)
  );

  // Mode selected by a prefixed byte (R4), -1 if none
  function automatic int mode_of(input logic [7:0] c);
    case (c)
      8'h46, 8'h4E, 8'h66, 8'h6E: return 0;
      8'h56, 8'h76: return 1;
      8'h5E, 8'h7E: return 2;
      default: return -1;
    endcase
  endfunction

  // 1 = non-maskable return (R5), 2 = maskable return (R6), 0 = neither
  function automatic int ret_of(input logic [7:0] c);
    case (c)
      8'h45, 8'h55, 8'h65, 8'h75: return 1;
      8'h4D, 8'h5D, 8'h6D, 8'h7D: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " int_enabled"}, int_enabled, e1);
    chk({req, " nmi_shadow"}, nmi_shadow, e2);
    chk({req, " irq_mode"}, irq_mode, emode);
    chk({req, " pop_req"}, pop_req, ebusy);
  endtask

  // One cycle: inputs already driven; update model at the edge, check after it.
  task automatic step(input string req);
    logic n1, n2;
    @(posedge clk);
    n1 = e1; n2 = e2;
    if (ebusy) begin
      if (pop_ack) begin
        ebusy = 1'b0;
        if (ekind_nmi) n1 = e2;
      end
    end else if (insn_done) begin
      if (!insn_prefixed) begin
        if (insn_code == 8'hFB) begin n1 = 1; n2 = 1; end
        if (insn_code == 8'hF3) begin n1 = 0; n2 = 0; end
      end else begin
        if (mode_of(insn_code) >= 0) emode = 2'(mode_of(insn_code));
        if (ret_of(insn_code) != 0) begin
          ebusy = 1'b1;
          ekind_nmi = (ret_of(insn_code) == 1);
        end
      end
    end
    if (nmi_take) n1 = 0;
    if (irq_take) begin n1 = 0; n2 = 0; end
    e1 = n1; e2 = n2;
    @(negedge clk);
    check_all(req);
  endtask

  task automatic drive(input logic d, input logic p, input logic [7:0] c,
                       input logic nt, input logic it, input logic ak);
    insn_done = d; insn_prefixed = p; insn_code = c;
    nmi_take = nt; irq_take = it; pop_ack = ak;
  endtask

  task automatic op(input logic p, input logic [7:0] c, input string req);
    drive(1, p, c, 0, 0, 0);
    step(req);
    drive(0, 0, 8'h00, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [7:0] pool [0:17];

  initial begin
    int seed;
    seed = 32'h1F2E3D;
    void'($urandom(seed));
    pool = '{8'hFB, 8'hF3, 8'h46, 8'h4E, 8'h66, 8'h6E, 8'h56, 8'h76, 8'h5E,
             8'h7E, 8'h45, 8'h55, 8'h65, 8'h75, 8'h4D, 8'h5D, 8'h6D, 8'h7D};
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // Directed corner cases
    op(0, 8'hFB, "R2");
    op(1, 8'h5E, "R4");
    op(1, 8'h76, "R4");
    op(1, 8'h6E, "R4");
    op(1, 8'hFB, "R9 prefixed enable");
    op(0, 8'h56, "R9 unprefixed mode byte");
    drive(0, 1, 8'h7E, 0, 0, 0); step("R9 no strobe");
    drive(0, 0, 8'h00, 1, 0, 0); step("R7");          // iff1=0, iff2=1
    op(1, 8'h65, "R5 request");
    drive(1, 0, 8'hF3, 0, 0, 0); step("R10 busy ignores");
    drive(0, 0, 8'h00, 0, 0, 0); step("R5 held");
    drive(0, 0, 8'h00, 0, 0, 1); step("R5 restore");  // iff1 <- 1
    drive(0, 0, 8'h00, 0, 0, 1); step("R10 stray ack");
    op(0, 8'hF3, "R3");
    op(0, 8'hFB, "R2");
    op(1, 8'h7D, "R6 request");
    drive(0, 0, 8'h00, 0, 1, 1); step("R8 over ack"); // both cleared
    op(0, 8'hFB, "R2");
    op(1, 8'h45, "R5 request");
    drive(0, 0, 8'h00, 1, 0, 1); step("R7 over restore");

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] c;
      logic p;
      int r;
      r = $urandom_range(0, 9);
      if (r < 7) begin
        c = pool[$urandom_range(0, 17)];
        p = (c != 8'hFB && c != 8'hF3);
        if ($urandom_range(0, 9) == 0) p = ~p;
      end else begin
        c = 8'($urandom);
        p = 1'($urandom);
      end
      drive($urandom_range(0, 2) != 0, p, c,
            $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
            $urandom_range(0, 2) == 0);
      step("R2-R10 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule